// File: doc/BRIEF.md
# Sleep-Mode PMIC Signaling Sequencer

This block sequences the two control pins an external power IC watches while the core goes to sleep and wakes again: a clock-request pin and an off-mode pin. The core raises `sleep_req` when it is ready to idle, and the sequencer works through the path chosen in its mode register. For a plain automatic sleep it only drops the clock request. For retention, and for off signalled over I2C, it first hands one command to an I2C engine and then waits a programmed setup count. For off signalled by pin it asserts the off-mode pin and drops the clock request. All waits count ticks of a 32.768 kHz strobe (`tick_32k`), and the system clock runs much faster.

Off by pin splits its wait into two segments. The first is a fixed oscillator-shutdown offset, about 488 µs rounded up to 16 slow ticks, and it runs while only the off-mode pin is asserted. The second is the remaining voltage-setup count, and it runs after the clock request has also dropped. The two segments add up to the clock-setup time, which is derived from the programmed oscillator start-up time. When `wake_req` arrives, the sequencer restores both pins at once. It then waits the full setup count of the path it took and pulses `wake_done`. A wake that arrives during an entry count aborts the entry.

The I2C command leaves through a valid/ready stream with a one-bit payload (`i2c_is_off`). Once `i2c_valid` rises, it and the payload stay unchanged until a cycle with `i2c_ready` high. The command is accepted on that cycle. Holding `i2c_ready` low stalls the sequence for as long as it stays low. No timing count runs while the command is pending. Every other pin is a plain level or pulse.

Top module: `sleep_sig_seq`

## Requirements
- R1: A mode write (`mode_wr`) with code 1, 2 or 3 sets exactly one bit of `auto_en` (bit 0 retention, bit 1 sleep, bit 2 off) and clears the other two. Code 0 clears all three. `mode_off_i2c` written at the same time selects I2C (1) or pin (0) signalling for off.
- R2: `sleep_req` has no effect while `auto_en` is zero or while a sequence is already under way: the pins, `done` and `i2c_valid` stay as they were.
- R3: Retention raises `i2c_valid` with `i2c_is_off`=0. After acceptance it waits `ret_setup` ticks, then drops only the clock request and raises `done`.
- R4: Off by pin asserts the off-mode pin first and holds the clock request on for exactly 16 ticks. It then drops the clock request, waits the remaining setup count, and raises `done`. The whole entry takes exactly the clock-setup time.
- R5: Clock setup is ceil(32768·µs/1e6) of `osc_start_us`, or of 10000 µs (328 ticks) when `osc_start_us` is 0. The second segment is clock setup minus 16, floored at 0.
- R6: Off by I2C raises `i2c_valid` with `i2c_is_off`=1. After acceptance it waits `off_setup` ticks, then drops the clock request. The off-mode pin is never asserted on this path.
- R7: Automatic sleep drops the clock request at once with no I2C command and no wait. Its wake completes immediately.
- R8: After reset the clock-request pin is active high and the off-mode pin active low. A polarity write (`pol_wr`) loads `pol_clk_hi`/`pol_off_hi`, where 1 means active high, and each pin level is its logical state mapped through that bit.
- R9: `wake_req` while asleep restores both pins immediately. It then waits the path's full setup count (retention `ret_setup`, I2C off `off_setup`, pin off clock setup, sleep zero) and pulses `wake_done` for one cycle, with `done` low.
- R10: `wake_req` during an entry count aborts the entry. The wake wait then runs in full, and `done` never rises. `wake_req` while an I2C command is pending has no effect.
- R11: Once `i2c_valid` is high it stays high, with `i2c_is_off` stable, until a cycle with `i2c_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_32k | input | 1 | One-cycle strobe per 32.768 kHz period |
| mode_wr | input | 1 | Mode register write strobe |
| mode_code | input | 2 | 0 none, 1 retention, 2 sleep, 3 off |
| mode_off_i2c | input | 1 | Off signalled over I2C (1) or by pin (0) |
| pol_wr | input | 1 | Polarity register write strobe |
| pol_clk_hi | input | 1 | Clock-request pin active high when 1 |
| pol_off_hi | input | 1 | Off-mode pin active high when 1 |
| osc_start_us | input | US_W | Oscillator start-up time in µs, 0 = default |
| ret_setup | input | CNT_W | Retention voltage-setup count in ticks |
| off_setup | input | CNT_W | I2C-off voltage-setup count in ticks |
| sleep_req | input | 1 | Core ready to idle |
| wake_req | input | 1 | Wake event |
| i2c_valid | output | 1 | Command request toward the I2C engine |
| i2c_ready | input | 1 | I2C engine accepts the command |
| i2c_is_off | output | 1 | Command payload: 1 off, 0 retention |
| clkreq_pin | output | 1 | Clock-request pin level |
| offmode_pin | output | 1 | Off-mode pin level |
| done | output | 1 | Sleep entry complete, held while asleep |
| wake_done | output | 1 | One-cycle pulse when wake completes |
| auto_en | output | 3 | One-hot automatic mode enables |

## Verification
The in-line properties check the following on every cycle:
- the mode enables are one-hot after a write;
- the I2C request holds steady under back-pressure;
- `wake_done` is a single pulse;
- `done` never coexists with an active clock request;
- the off-mode pin is asserted only on the pin-off path;
- a wake during an entry count keeps `done` low;
- the second timing segment plus the offset equals the clock setup.

Only the scenarios can show the exact tick counts of each wait, because those counts depend on the programmed times. The scenarios also cover the split of the pin-off entry into its 16-tick offset and its remainder, the pin levels under both polarities, and the effect of an aborted entry or of a wake during a pending command.

// File: rtl/sleep_sig_pkg.sv
package sleep_sig_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_I2C_REQ,
    ST_ENTRY_WAIT,
    ST_OFF_SHUT,
    ST_OFF_VSET,
    ST_ASLEEP,
    ST_WAKE
  } seq_state_e;

  typedef enum logic [1:0] {
    PATH_SLEEP,
    PATH_RET,
    PATH_OFF_PIN,
    PATH_OFF_I2C
  } sig_path_e;

  // Microseconds to slow-clock ticks, rounded up.
  function automatic logic [31:0] us_to_slow(input logic [31:0] us, input int unsigned hz);
    logic [63:0] prod;
    prod = 64'(us) * 64'(hz) + 64'd999999;
    return 32'(prod / 64'd1000000);
  endfunction

endpackage

// File: rtl/sig_mode_reg.sv
module sig_mode_reg #(
  parameter int unsigned N_MODES = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_wr,
  input  logic [1:0]         mode_code,
  input  logic               mode_off_i2c,
  input  logic               pol_wr,
  input  logic               pol_clk_hi,
  input  logic               pol_off_hi,
  output logic [N_MODES-1:0] auto_en,
  output logic               off_i2c,
  output logic               pol_clk,
  output logic               pol_off
);

  logic [N_MODES-1:0] en_dec;

  // Each enable bit corresponds to one nonzero code value.
  for (genvar g = 0; g < N_MODES; g++) begin : g_dec
    assign en_dec[g] = (mode_code == 2'(g + 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      auto_en <= '0;
      off_i2c <= 1'b0;
    end else if (mode_wr) begin
      auto_en <= en_dec;
      off_i2c <= mode_off_i2c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_clk <= 1'b1;
      pol_off <= 1'b0;
    end else if (pol_wr) begin
      pol_clk <= pol_clk_hi;
      pol_off <= pol_off_hi;
    end
  end

  AST_MODE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> ($onehot0(auto_en) && ((auto_en != '0) == ($past(mode_code) != 2'd0)))); // R1

endmodule

// File: rtl/sig_timing_calc.sv
module sig_timing_calc
  import sleep_sig_pkg::*;
#(
  parameter int unsigned US_W       = 16,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned TICK_HZ    = 32768,
  parameter int unsigned VOFF_US    = 488,
  parameter int unsigned DEF_OSC_US = 10000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [US_W-1:0]  osc_start_us,
  output logic [CNT_W-1:0] clk_setup,
  output logic [CNT_W-1:0] vset_rem
);

  localparam logic [CNT_W-1:0] VOFF_CYC = CNT_W'(us_to_slow(32'(VOFF_US), TICK_HZ));

  logic [31:0]      osc_eff;
  logic [CNT_W-1:0] raw_cyc;

  always_comb begin
    osc_eff = (osc_start_us == '0) ? 32'(DEF_OSC_US) : 32'(osc_start_us);
    raw_cyc = CNT_W'(us_to_slow(osc_eff, TICK_HZ));
  end

  // A start-up time shorter than the offset collapses to the offset alone.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_setup <= VOFF_CYC;
      vset_rem  <= '0;
    end else if (raw_cyc >= VOFF_CYC) begin
      clk_setup <= raw_cyc;
      vset_rem  <= raw_cyc - VOFF_CYC;
    end else begin
      clk_setup <= VOFF_CYC;
      vset_rem  <= '0;
    end
  end

  AST_SETUP_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    (CNT_W'(vset_rem + VOFF_CYC) == clk_setup)); // R5

endmodule

// File: rtl/sig_tick_counter.sv
module sig_tick_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             expire
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (load)                cnt <= load_val;
    else if (tick && cnt != '0)   cnt <= cnt - 1'b1;
  end

  // Expires on the tick that consumes the last count, or at once when empty.
  assign expire = (cnt == '0) || (cnt == CNT_W'(1) && tick);

  AST_CNT_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt == '0) |=> (cnt == '0)); // R4

endmodule

// File: rtl/sleep_sig_seq.sv
module sleep_sig_seq
  import sleep_sig_pkg::*;
#(
  parameter int unsigned US_W       = 16,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned TICK_HZ    = 32768,
  parameter int unsigned VOFF_US    = 488,
  parameter int unsigned DEF_OSC_US = 10000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_32k,
  input  logic             mode_wr,
  input  logic [1:0]       mode_code,
  input  logic             mode_off_i2c,
  input  logic             pol_wr,
  input  logic             pol_clk_hi,
  input  logic             pol_off_hi,
  input  logic [US_W-1:0]  osc_start_us,
  input  logic [CNT_W-1:0] ret_setup,
  input  logic [CNT_W-1:0] off_setup,
  input  logic             sleep_req,
  input  logic             wake_req,
  output logic             i2c_valid,
  input  logic             i2c_ready,
  output logic             i2c_is_off,
  output logic             clkreq_pin,
  output logic             offmode_pin,
  output logic             done,
  output logic             wake_done,
  output logic [2:0]       auto_en
);

  localparam logic [CNT_W-1:0] VOFF_CYC = CNT_W'(us_to_slow(32'(VOFF_US), TICK_HZ));
  localparam int unsigned      EN_RET   = 0;
  localparam int unsigned      EN_SLEEP = 1;

  logic             off_i2c, pol_clk, pol_off;
  logic [CNT_W-1:0] clk_setup, vset_rem;
  logic             cnt_load, cnt_expire;
  logic [CNT_W-1:0] cnt_val;

  seq_state_e st_q, st_d;
  sig_path_e  path_q, path_d;
  logic       wdone_q, wdone_d;
  logic       go_wake;
  logic [CNT_W-1:0] wake_n, setup1_n;
  logic       clk_req_on, off_act;

  sig_mode_reg #(.N_MODES(3)) u_mode (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_wr      (mode_wr),
    .mode_code    (mode_code),
    .mode_off_i2c (mode_off_i2c),
    .pol_wr       (pol_wr),
    .pol_clk_hi   (pol_clk_hi),
    .pol_off_hi   (pol_off_hi),
    .auto_en      (auto_en),
    .off_i2c      (off_i2c),
    .pol_clk      (pol_clk),
    .pol_off      (pol_off)
  );

  sig_timing_calc #(
    .US_W(US_W), .CNT_W(CNT_W), .TICK_HZ(TICK_HZ),
    .VOFF_US(VOFF_US), .DEF_OSC_US(DEF_OSC_US)
  ) u_calc (
    .clk          (clk),
    .rst_n        (rst_n),
    .osc_start_us (osc_start_us),
    .clk_setup    (clk_setup),
    .vset_rem     (vset_rem)
  );

  sig_tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (cnt_val),
    .tick     (tick_32k),
    .expire   (cnt_expire)
  );

  // Wake length depends on the path that was taken on entry.
  always_comb begin
    unique case (path_q)
      PATH_RET:     wake_n = ret_setup;
      PATH_OFF_I2C: wake_n = off_setup;
      PATH_OFF_PIN: wake_n = clk_setup;
      default:      wake_n = '0;
    endcase
    setup1_n = (path_q == PATH_RET) ? ret_setup : off_setup;
  end

  always_comb begin
    st_d     = st_q;
    path_d   = path_q;
    cnt_load = 1'b0;
    cnt_val  = '0;
    wdone_d  = 1'b0;
    go_wake  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (sleep_req && auto_en != 3'b000) begin
          if (auto_en[EN_SLEEP]) begin
            path_d = PATH_SLEEP;
            st_d   = ST_ASLEEP;
          end else if (auto_en[EN_RET]) begin
            path_d = PATH_RET;
            st_d   = ST_I2C_REQ;
          end else if (off_i2c) begin
            path_d = PATH_OFF_I2C;
            st_d   = ST_I2C_REQ;
          end else begin
            path_d   = PATH_OFF_PIN;
            st_d     = ST_OFF_SHUT;
            cnt_load = 1'b1;
            cnt_val  = VOFF_CYC;
          end
        end
      end
      ST_I2C_REQ: begin
        if (i2c_ready) begin
          if (setup1_n == '0) begin
            st_d = ST_ASLEEP;
          end else begin
            st_d     = ST_ENTRY_WAIT;
            cnt_load = 1'b1;
            cnt_val  = setup1_n;
          end
        end
      end
      ST_ENTRY_WAIT, ST_OFF_VSET: begin
        if (wake_req)        go_wake = 1'b1;
        else if (cnt_expire) st_d    = ST_ASLEEP;
      end
      ST_OFF_SHUT: begin
        if (wake_req) begin
          go_wake = 1'b1;
        end else if (cnt_expire) begin
          if (vset_rem == '0) begin
            st_d = ST_ASLEEP;
          end else begin
            st_d     = ST_OFF_VSET;
            cnt_load = 1'b1;
            cnt_val  = vset_rem;
          end
        end
      end
      ST_ASLEEP: begin
        if (wake_req) go_wake = 1'b1;
      end
      ST_WAKE: begin
        if (cnt_expire) begin
          st_d    = ST_IDLE;
          wdone_d = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (go_wake) begin
      if (wake_n == '0) begin
        st_d    = ST_IDLE;
        wdone_d = 1'b1;
      end else begin
        st_d     = ST_WAKE;
        cnt_load = 1'b1;
        cnt_val  = wake_n;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      path_q  <= PATH_SLEEP;
      wdone_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      path_q  <= path_d;
      wdone_q <= wdone_d;
    end
  end

  // Logical pin states, then polarity mapping.
  always_comb begin
    clk_req_on = !(st_q == ST_ASLEEP || st_q == ST_OFF_VSET);
    off_act    = (path_q == PATH_OFF_PIN) &&
                 (st_q == ST_OFF_SHUT || st_q == ST_OFF_VSET || st_q == ST_ASLEEP);
  end

  assign clkreq_pin  = pol_clk ? clk_req_on : !clk_req_on;
  assign offmode_pin = pol_off ? off_act : !off_act;
  assign done        = (st_q == ST_ASLEEP);
  assign wake_done   = wdone_q;
  assign i2c_valid   = (st_q == ST_I2C_REQ);
  assign i2c_is_off  = (path_q == PATH_OFF_I2C);

  AST_I2C_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (i2c_valid && !i2c_ready) |=> (i2c_valid && $stable(i2c_is_off))); // R11

  AST_WAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_done |=> !wake_done); // R9

  AST_DONE_NO_CLKREQ: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !clk_req_on); // R3

  AST_OFF_PIN_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    off_act |-> (path_q == PATH_OFF_PIN)); // R6

  AST_ABORT_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_req && (st_q == ST_ENTRY_WAIT || st_q == ST_OFF_SHUT || st_q == ST_OFF_VSET))
      |=> !done); // R10

endmodule

// File: tb/sleep_sig_seq_tb.sv
module sleep_sig_seq_tb;

  localparam int CNT_W = 16;
  localparam int US_W  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_32k = 1'b0;
  logic mode_wr = 1'b0;
  logic [1:0] mode_code = 2'd0;
  logic mode_off_i2c = 1'b0;
  logic pol_wr = 1'b0, pol_clk_hi = 1'b1, pol_off_hi = 1'b0;
  logic [US_W-1:0] osc_start_us = '0;
  logic [CNT_W-1:0] ret_setup = 16'd7, off_setup = 16'd11;
  logic sleep_req = 1'b0, wake_req = 1'b0;
  logic i2c_valid, i2c_ready = 1'b0, i2c_is_off;
  logic clkreq_pin, offmode_pin, done, wake_done;
  logic [2:0] auto_en;

  sleep_sig_seq u_dut (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k),
    .mode_wr(mode_wr), .mode_code(mode_code), .mode_off_i2c(mode_off_i2c),
    .pol_wr(pol_wr), .pol_clk_hi(pol_clk_hi), .pol_off_hi(pol_off_hi),
    .osc_start_us(osc_start_us), .ret_setup(ret_setup), .off_setup(off_setup),
    .sleep_req(sleep_req), .wake_req(wake_req),
    .i2c_valid(i2c_valid), .i2c_ready(i2c_ready), .i2c_is_off(i2c_is_off),
    .clkreq_pin(clkreq_pin), .offmode_pin(offmode_pin),
    .done(done), .wake_done(wake_done), .auto_en(auto_en)
  );

  always #4 clk = ~clk;  // 125 MHz

  typedef struct {
    int    kind;   // 1 entry, 2 wake
    int    ticks;
    int    shut;
    int    cpin;
    int    opin;
    int    i2ck;   // -1 no command expected
    string req;
  } item_t;

  item_t exp_q[$];
  int n_chk = 0, n_fail = 0;
  int phase = 0;          // 0 idle, 1 entry, 2 wake, 3 aborting entry
  int tick_cnt = 0, shut_cnt = 0, seen_kind = -1;
  int tdiv = 0;
  int vcnt = 0;
  bit block_ready = 1'b0;
  bit done_in_abort = 1'b0;
  bit pc = 1'b1, po = 1'b0;  // bench copy of programmed polarity
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic int pin_of(input bit logical, input bit pol);
    return pol ? int'(logical) : int'(!logical);
  endfunction

  // Tick generator and monitor: decide the tick for the next edge, then observe.
  always @(negedge clk) begin
    item_t e;
    bit t;
    bit clk_on, off_on;
    t = (tdiv == 0);
    tdiv = (tdiv + 1) % 3;
    tick_32k = t;
    clk_on = pc ? clkreq_pin : !clkreq_pin;
    off_on = po ? offmode_pin : !offmode_pin;
    if (i2c_valid && i2c_ready) seen_kind = int'(i2c_is_off);
    if (phase == 3 && done) done_in_abort = 1'b1;
    if (phase == 1) begin
      if (done) begin
        phase = 0;
        if (exp_q.size() == 0) chk(1'b0, "R3 scoreboard empty", 0, 1);
        else begin
          e = exp_q.pop_front();
          chk(e.kind == 1, {e.req, " item kind"}, 1, e.kind);
          chk(tick_cnt == e.ticks, {e.req, " entry ticks"}, tick_cnt, e.ticks);
          chk(shut_cnt == e.shut, {e.req, " offset ticks"}, shut_cnt, e.shut);
          chk(int'(clkreq_pin) == e.cpin, {e.req, " clkreq pin asleep"}, int'(clkreq_pin), e.cpin);
          chk(int'(offmode_pin) == e.opin, {e.req, " offmode pin asleep"}, int'(offmode_pin), e.opin);
          chk(seen_kind == e.i2ck, {e.req, " i2c payload"}, seen_kind, e.i2ck);
        end
      end else begin
        if (!i2c_valid && t) tick_cnt++;
        if (off_on && clk_on && t) shut_cnt++;
      end
    end else if (phase == 2) begin
      if (wake_done) begin
        phase = 0;
        if (exp_q.size() == 0) chk(1'b0, "R9 scoreboard empty", 0, 1);
        else begin
          e = exp_q.pop_front();
          chk(e.kind == 2, {e.req, " item kind"}, 2, e.kind);
          chk(tick_cnt == e.ticks, {e.req, " wake ticks"}, tick_cnt, e.ticks);
          chk(int'(clkreq_pin) == e.cpin, {e.req, " clkreq pin awake"}, int'(clkreq_pin), e.cpin);
          chk(int'(offmode_pin) == e.opin, {e.req, " offmode pin awake"}, int'(offmode_pin), e.opin);
          chk(done == 1'b0, {e.req, " done low after wake"}, int'(done), 0);
        end
      end else if (t) tick_cnt++;
    end
  end

  // I2C responder: accept after a few cycles unless blocked.
  always @(posedge clk) begin
    #1;
    if (i2c_valid && !block_ready) begin
      vcnt++;
      i2c_ready = (vcnt >= 3);
    end else begin
      vcnt = 0;
      i2c_ready = 1'b0;
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic wr_mode(input logic [1:0] code, input bit via_i2c);
    @(posedge clk); #1;
    mode_wr = 1'b1; mode_code = code; mode_off_i2c = via_i2c;
    @(posedge clk); #1;
    mode_wr = 1'b0;
  endtask

  task automatic wr_pol(input bit c, input bit o);
    @(posedge clk); #1;
    pol_wr = 1'b1; pol_clk_hi = c; pol_off_hi = o;
    @(posedge clk); #1;
    pol_wr = 1'b0; pc = c; po = o;
  endtask

  task automatic push(input int kind, input int ticks, input int shut,
                      input int cpin, input int opin, input int i2ck, input string req);
    item_t e;
    e.kind = kind; e.ticks = ticks; e.shut = shut;
    e.cpin = cpin; e.opin = opin; e.i2ck = i2ck; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic pulse_sleep();
    @(posedge clk); #1; sleep_req = 1'b1;
    @(posedge clk); #1; sleep_req = 1'b0;
  endtask

  task automatic do_entry(input int ticks, input int shut, input int cpin,
                          input int opin, input int i2ck, input string req);
    push(1, ticks, shut, cpin, opin, i2ck, req);
    seen_kind = -1;
    pulse_sleep();
    tick_cnt = 0; shut_cnt = 0; phase = 1;
    while (phase != 0) @(posedge clk);
    #1;
  endtask

  task automatic do_wake(input int ticks, input int cpin, input int opin, input string req);
    push(2, ticks, 0, cpin, opin, -1, req);
    @(posedge clk); #1; wake_req = 1'b1;
    @(posedge clk); #1; wake_req = 1'b0;
    tick_cnt = 0; phase = 2;
    while (phase != 0) @(posedge clk);
    #1;
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    // Reset state
    chk(clkreq_pin == 1'b1, "R8 reset clkreq pin", int'(clkreq_pin), 1);
    chk(offmode_pin == 1'b1, "R8 reset offmode pin", int'(offmode_pin), 1);
    chk(done == 1'b0 && i2c_valid == 1'b0, "R2 reset idle", int'(done), 0);
    chk(auto_en == 3'b000, "R1 reset modes", int'(auto_en), 0);

    // R2: no mode selected, sleep ignored
    pulse_sleep();
    cyc(10);
    chk(done == 1'b0 && i2c_valid == 1'b0, "R2 sleep ignored without mode", int'(done), 0);
    chk(clkreq_pin == 1'b1 && offmode_pin == 1'b1, "R2 pins unchanged", int'(clkreq_pin), 1);

    // R1 mode exclusivity
    wr_mode(2'd1, 1'b0); cyc(1);
    chk(auto_en == 3'b001, "R1 retention only", int'(auto_en), 1);
    wr_mode(2'd2, 1'b0); cyc(1);
    chk(auto_en == 3'b010, "R1 sleep only", int'(auto_en), 2);
    wr_mode(2'd3, 1'b0); cyc(1);
    chk(auto_en == 3'b100, "R1 off only", int'(auto_en), 4);

    // R4/R5 pin off with default oscillator time: 328 = 16 + 312
    osc_start_us = '0; cyc(3);
    do_entry(328, 16, 0, 0, -1, "R4 R5 pin off default");
    pulse_sleep(); cyc(5);
    chk(done == 1'b1 && clkreq_pin == 1'b0 && offmode_pin == 1'b0,
        "R2 sleep while asleep ignored", int'(done), 1);
    do_wake(328, 1, 1, "R9 pin off wake");

    // R5 programmed 2000 us -> 66 ticks
    osc_start_us = 16'd2000; cyc(3);
    do_entry(66, 16, 0, 0, -1, "R4 R5 pin off 2000us");
    do_wake(66, 1, 1, "R9 pin off wake 2000us");

    // R3 retention
    wr_mode(2'd1, 1'b0);
    do_entry(7, 0, 0, 1, 0, "R3 retention");
    do_wake(7, 1, 1, "R9 retention wake");

    // R6 off via I2C
    wr_mode(2'd3, 1'b1);
    do_entry(11, 0, 0, 1, 1, "R6 off over i2c");
    do_wake(11, 1, 1, "R9 i2c off wake");

    // R7 plain sleep
    wr_mode(2'd2, 1'b0);
    do_entry(0, 0, 0, 1, -1, "R7 sleep entry");
    do_wake(0, 1, 1, "R7 sleep wake");

    // R8 inverted polarity
    wr_pol(1'b0, 1'b1); cyc(1);
    chk(clkreq_pin == 1'b0 && offmode_pin == 1'b0, "R8 inverted idle pins",
        int'({clkreq_pin, offmode_pin}), 0);
    wr_mode(2'd3, 1'b0);
    do_entry(66, 16, 1, 1, -1, "R8 inverted pin off");
    do_wake(66, 0, 0, "R8 inverted wake");
    wr_pol(1'b1, 1'b0);

    // R10 abort during offset segment, default oscillator time
    osc_start_us = '0; cyc(3);
    done_in_abort = 1'b0;
    pulse_sleep();
    phase = 3;
    cyc(20);
    chk(offmode_pin == 1'b0 && clkreq_pin == 1'b1, "R10 in offset segment",
        int'(offmode_pin), 0);
    do_wake(328, 1, 1, "R10 aborted entry wake");
    chk(done_in_abort == 1'b0, "R10 done never rose", int'(done_in_abort), 0);

    // R10 wake while I2C command pending is ignored
    wr_mode(2'd1, 1'b0);
    block_ready = 1'b1;
    push(1, 7, 0, 0, 1, 0, "R10 R11 stalled retention");
    seen_kind = -1;
    pulse_sleep();
    tick_cnt = 0; shut_cnt = 0; phase = 1;
    cyc(6);
    @(posedge clk); #1; wake_req = 1'b1;
    @(posedge clk); #1; wake_req = 1'b0;
    cyc(4);
    chk(i2c_valid == 1'b1 && i2c_is_off == 1'b0, "R11 request held under stall",
        int'(i2c_valid), 1);
    chk(done == 1'b0 && clkreq_pin == 1'b1, "R10 wake ignored while pending",
        int'(done), 0);
    block_ready = 1'b0;
    while (phase != 0) @(posedge clk);
    #1;
    do_wake(7, 1, 1, "R9 wake after stall");

    chk(exp_q.size() == 0, "R9 scoreboard drained", exp_q.size(), 0);
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule